// File: doc/BRIEF.md
# Video Output Field Handshake Controller

This block is the control and status core of a video output engine. It keeps the enable, soft-reset, operating-mode and interrupt-enable bits, captures timing events from a separate timing generator as sticky flags, and combines the enabled flags into one interrupt line. The pixel path, the memory interface and the pointer registers sit outside it.

Its central job is the end-of-field handshake. When a field ends, an end-of-field flag is raised. Software must then load new buffer pointers and acknowledge the flag. This acknowledge has to arrive before the active region of the next field begins. If it is late, the block raises an underrun flag and withholds the pointer-load pulse, so the engine keeps using the old pointers.

Memory reads follow the enable bit. In message mode the enable bit clears itself when the first buffer has drained.

Top module: `vfc_top`

## Requirements
- R1: A write to the clear register (address 1) with bit i set clears flag i. Flag bits are 0 = buffer-1 empty, 1 = buffer-2 empty, 2 = horizontal blank end, 3 = underrun and 4 = end-of-field. Bit 4 is the end-of-field acknowledge. Each flag stays set until it is cleared this way.
- R2: When a flag's set event and its clear bit arrive in the same cycle, the flag ends up set.
- R3: An active-start event raises the underrun flag when all of the following hold in that cycle: end-of-field is set, the same cycle carries no acknowledge, and soft reset is off. In that case ptr_load stays low. Otherwise an active-start event outside soft reset gives a one-cycle ptr_load pulse in the next cycle.
- R4: irq is the OR of (flag AND interrupt enable) over all flags, registered, so it follows one cycle after the flags. The interrupt enable bits are control bits [8:4], one per flag index.
- R5: The control register is at address 0. Its fields are en at bit 0, srst at bit 1 and mode at [3:2], where 0 = video refresh, 1 = streaming and 2 = message. In message mode a buffer-1-empty event clears en while en is set.
- R6: In video and streaming modes a buffer-1-empty event leaves en unchanged.
- R7: mem_rd_en equals (en AND NOT srst) one cycle late. With en low in video mode, flags and irq keep working.
- R8: While srst is set, all flags are cleared from the next cycle on and held at zero, events are ignored and ptr_load stays low.
- R9: A control write with srst=1 and en=1 sets srst and forces en to 0.
- R10: After rst, all control bits, flags, irq, mem_rd_en and ptr_load are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | 0 = control, 1 = flag clear |
| wr_data | input | NFLAG+4 | Write data |
| ev_buf1_empty | input | 1 | Buffer 1 drained |
| ev_buf2_empty | input | 1 | Buffer 2 drained |
| ev_hblank_end | input | 1 | Horizontal blank ended |
| ev_active_start | input | 1 | Next field's active region begins |
| ev_field_end | input | 1 | Field ended |
| ctl_enable | output | 1 | Enable bit |
| ctl_soft_rst | output | 1 | Soft-reset bit |
| flags | output | NFLAG | Sticky flags |
| mem_rd_en | output | 1 | Memory read enable |
| ptr_load | output | 1 | Pointer-load pulse |
| irq | output | 1 | Interrupt |

## Verification
The hardest cases to reach from the ports are coincident events. These are the acknowledge write landing in the same cycle as active start, and a field-end event landing together with its own acknowledge. The stimulus table drives the write port and the event inputs in one cycle to reach both cases. It then follows the same end-of-field flag through a missed deadline and through an on-time acknowledge. The message-mode self-clear is reached only after switching the mode with enable set, so the table makes that mode change just before it raises the drain event.

// File: rtl/vfc_pkg.sv
package vfc_pkg;
  localparam int NFLAG   = 5;
  localparam int FL_B1   = 0;
  localparam int FL_B2   = 1;
  localparam int FL_HBE  = 2;
  localparam int FL_URUN = 3;
  localparam int FL_EOF  = 4;

  typedef enum logic [1:0] {
    MODE_VIDEO  = 2'd0,
    MODE_STREAM = 2'd1,
    MODE_MSG    = 2'd2,
    MODE_RSVD   = 2'd3
  } vmode_e;

  typedef struct packed {
    logic [NFLAG-1:0] ie;
    vmode_e           mode;
    logic             srst;
    logic             en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/vfc_ctrl_reg.sv
module vfc_ctrl_reg
  import vfc_pkg::*;
#(
  parameter int ADDR_W    = 1,
  parameter int CTRL_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              drain_ev,
  output ctrl_t             ctrl_q
);
  ctrl_t ctrl_d;
  logic  hit;

  assign hit = wr_en && (wr_addr == ADDR_W'(CTRL_ADDR));

  always_comb begin
    ctrl_d = ctrl_q;
    if (hit) begin
      ctrl_d = ctrl_t'(wr_data);
      // illegal combination: reset wins, enable dropped
      if (ctrl_d.srst) ctrl_d.en = 1'b0;
    end
    // message transfer ends when buffer 1 drains
    if (ctrl_q.mode == MODE_MSG && ctrl_q.en && drain_ev) ctrl_d.en = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else     ctrl_q <= ctrl_d;
  end

  a_r5_msg_selfclear: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q.mode == MODE_MSG && ctrl_q.en && drain_ev) |=> !ctrl_q.en);
  a_r9_no_en_in_reset: assert property (@(posedge clk) disable iff (rst)
    ctrl_q.srst |-> !ctrl_q.en);
endmodule

// File: rtl/vfc_flag_cell.sv
module vfc_flag_cell (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst || hold) q <= 1'b0;
    else if (set)    q <= 1'b1;
    else if (clr)    q <= 1'b0;
  end

  a_r2_set_wins: assert property (@(posedge clk) disable iff (rst)
    (set && !hold) |=> q);
  a_r1_clear: assert property (@(posedge clk) disable iff (rst)
    (clr && !set && !hold) |=> !q);
endmodule

// File: rtl/vfc_handshake.sv
module vfc_handshake (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  input  logic active_start,
  input  logic eof_pend,
  input  logic ack,
  output logic urun_set,
  output logic ptr_load_q
);
  assign urun_set = active_start && eof_pend && !ack && !hold;

  always_ff @(posedge clk) begin
    if (rst) ptr_load_q <= 1'b0;
    else     ptr_load_q <= active_start && !hold && !urun_set;
  end

  a_r3_missed_no_load: assert property (@(posedge clk) disable iff (rst)
    (active_start && eof_pend && !ack && !hold) |=> !ptr_load_q);
  a_r3_ontime_load: assert property (@(posedge clk) disable iff (rst)
    (active_start && !eof_pend && !hold) |=> ptr_load_q);
endmodule

// File: rtl/vfc_irq.sv
module vfc_irq #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] flags,
  input  logic [N-1:0] ie,
  output logic         irq_q
);
  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(flags & ie);
  end

  a_r4_irq_follows: assert property (@(posedge clk) disable iff (rst)
    (|(flags & ie)) |=> irq_q);
  a_r4_irq_quiet: assert property (@(posedge clk) disable iff (rst)
    !(|(flags & ie)) |=> !irq_q);
endmodule

// File: rtl/vfc_top.sv
module vfc_top
  import vfc_pkg::*;
#(
  parameter int ADDR_W = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              ev_buf1_empty,
  input  logic              ev_buf2_empty,
  input  logic              ev_hblank_end,
  input  logic              ev_active_start,
  input  logic              ev_field_end,
  output logic              ctl_enable,
  output logic              ctl_soft_rst,
  output logic [NFLAG-1:0]  flags,
  output logic              mem_rd_en,
  output logic              ptr_load,
  output logic              irq
);
  localparam int CTRL_ADDR = 0;
  localparam int CLR_ADDR  = 1;

  ctrl_t            ctrl;
  logic [NFLAG-1:0] clr_vec;
  logic [NFLAG-1:0] set_vec;
  logic             urun_set;
  logic             rd_q;

  assign clr_vec = (wr_en && wr_addr == ADDR_W'(CLR_ADDR)) ? wr_data[NFLAG-1:0] : '0;

  vfc_ctrl_reg #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .drain_ev(ev_buf1_empty), .ctrl_q(ctrl)
  );

  vfc_handshake u_hs (
    .clk(clk), .rst(rst), .hold(ctrl.srst), .active_start(ev_active_start),
    .eof_pend(flags[FL_EOF]), .ack(clr_vec[FL_EOF]),
    .urun_set(urun_set), .ptr_load_q(ptr_load)
  );

  always_comb begin
    set_vec          = '0;
    set_vec[FL_B1]   = ev_buf1_empty;
    set_vec[FL_B2]   = ev_buf2_empty;
    set_vec[FL_HBE]  = ev_hblank_end;
    set_vec[FL_URUN] = urun_set;
    set_vec[FL_EOF]  = ev_field_end;
  end

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    vfc_flag_cell u_cell (
      .clk(clk), .rst(rst), .hold(ctrl.srst),
      .set(set_vec[i]), .clr(clr_vec[i]), .q(flags[i])
    );
  end

  vfc_irq #(.N(NFLAG)) u_irq (
    .clk(clk), .rst(rst), .flags(flags), .ie(ctrl.ie), .irq_q(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_q <= 1'b0;
    else     rd_q <= ctrl.en && !ctrl.srst;
  end

  assign mem_rd_en    = rd_q;
  assign ctl_enable   = ctrl.en;
  assign ctl_soft_rst = ctrl.srst;

  a_r8_hold_clears: assert property (@(posedge clk) disable iff (rst)
    ctrl.srst |=> (flags == '0));
  a_r7_read_follows: assert property (@(posedge clk) disable iff (rst)
    (ctrl.en && !ctrl.srst) |=> mem_rd_en);
endmodule

// File: tb/vfc_top_test.sv
module vfc_top_test;
  localparam int CLK_P = 10;
  localparam int NROW  = 23;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [0:0] wr_addr = '0;
  logic [8:0] wr_data = '0;
  logic [4:0] ev = '0;
  logic       ctl_enable, ctl_soft_rst, mem_rd_en, ptr_load, irq;
  logic [4:0] flags;
  int         n_chk = 0;
  int         n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  vfc_top uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ev_buf1_empty(ev[0]), .ev_buf2_empty(ev[1]), .ev_hblank_end(ev[2]),
    .ev_active_start(ev[3]), .ev_field_end(ev[4]),
    .ctl_enable(ctl_enable), .ctl_soft_rst(ctl_soft_rst), .flags(flags),
    .mem_rd_en(mem_rd_en), .ptr_load(ptr_load), .irq(irq)
  );

  // row: wen, addr, data[8:0], ev{fe,as,hbe,b2,b1}, expected flags{eof,urun,hbe,b2,b1}, expected en
  localparam logic [21:0] TV [NROW] = '{
    {1'b1,1'b0,9'h002,5'b00000,5'b00000,1'b0}, // R9 reset write
    {1'b1,1'b0,9'h000,5'b00000,5'b00000,1'b0},
    {1'b1,1'b0,9'h1F1,5'b00000,5'b00000,1'b1}, // R5 enable video
    {1'b0,1'b0,9'h000,5'b10000,5'b10000,1'b1}, // R1 field end sticky
    {1'b0,1'b0,9'h000,5'b01000,5'b11000,1'b1}, // R3 missed ack
    {1'b1,1'b1,9'h018,5'b00000,5'b00000,1'b1}, // R1 ack clears
    {1'b0,1'b0,9'h000,5'b10000,5'b10000,1'b1},
    {1'b1,1'b1,9'h010,5'b01000,5'b00000,1'b1}, // R3 ack same cycle as start
    {1'b1,1'b1,9'h010,5'b10000,5'b10000,1'b1}, // R2 set wins
    {1'b0,1'b0,9'h000,5'b00111,5'b10111,1'b1},
    {1'b1,1'b1,9'h01F,5'b00000,5'b00000,1'b1}, // R1 clear all
    {1'b1,1'b0,9'h1F0,5'b00000,5'b00000,1'b0},
    {1'b0,1'b0,9'h000,5'b00001,5'b00001,1'b0}, // R7 flags while disabled
    {1'b1,1'b0,9'h1F9,5'b00000,5'b00001,1'b1}, // R5 message mode
    {1'b0,1'b0,9'h000,5'b00010,5'b00011,1'b1},
    {1'b0,1'b0,9'h000,5'b00001,5'b00011,1'b0}, // R5 self clear
    {1'b1,1'b0,9'h1F5,5'b00000,5'b00011,1'b1}, // R6 streaming
    {1'b0,1'b0,9'h000,5'b00001,5'b00011,1'b1}, // R6 enable persists
    {1'b1,1'b0,9'h003,5'b00000,5'b00011,1'b0}, // R9 illegal write
    {1'b0,1'b0,9'h000,5'b00000,5'b00000,1'b0}, // R8 flags cleared
    {1'b0,1'b0,9'h000,5'b11111,5'b00000,1'b0}, // R8 events ignored
    {1'b1,1'b0,9'h000,5'b00000,5'b00000,1'b0},
    {1'b1,1'b0,9'h001,5'b00000,5'b00000,1'b1}
  };
  localparam int TR [NROW] = '{9,9,5,1,3,1,1,3,2,1,1,6,7,5,5,5,6,6,9,8,8,8,5};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic we, input logic a, input logic [8:0] d, input logic [4:0] e);
    wr_en = we; wr_addr = a; wr_data = d; ev = e;
    @(posedge clk);
    #(CLK_P/4);
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; ev = '0;
  endtask

  initial begin
    #(CLK_P * 100000);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired (all requirements)");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #(CLK_P/4);
    chk("R10 flags", 32'(flags), 0);
    chk("R10 irq", 32'(irq), 0);
    chk("R10 mem_rd_en", 32'(mem_rd_en), 0);
    chk("R10 ptr_load", 32'(ptr_load), 0);
    chk("R10 enable", 32'({ctl_enable, ctl_soft_rst}), 0);
    rst = 1'b0;

    for (int i = 0; i < NROW; i++) begin
      step(TV[i][21], TV[i][20], TV[i][19:11], TV[i][10:6]);
      chk($sformatf("R%0d row %0d flags", TR[i], i), 32'(flags), 32'(TV[i][5:1]));
      chk($sformatf("R%0d row %0d enable", TR[i], i), 32'(ctl_enable), 32'(TV[i][0]));
    end

    // R7 read enable latency
    step(1'b1, 1'b0, 9'h010, 5'b0);
    step(1'b0, 1'b0, 9'h000, 5'b0);
    chk("R7 rd off", 32'(mem_rd_en), 0);
    step(1'b1, 1'b0, 9'h011, 5'b0);
    chk("R7 rd latency", 32'(mem_rd_en), 0);
    step(1'b0, 1'b0, 9'h000, 5'b0);
    chk("R7 rd on", 32'(mem_rd_en), 1);

    // R4 interrupt gating and latency
    step(1'b0, 1'b0, 9'h000, 5'b00010);
    step(1'b0, 1'b0, 9'h000, 5'b0);
    chk("R4 masked flag", 32'(irq), 0);
    step(1'b0, 1'b0, 9'h000, 5'b00001);
    chk("R4 irq latency", 32'(irq), 0);
    step(1'b0, 1'b0, 9'h000, 5'b0);
    chk("R4 irq raised", 32'(irq), 1);
    step(1'b1, 1'b1, 9'h003, 5'b0);
    chk("R4 flags cleared", 32'(flags), 0);
    chk("R4 irq lag", 32'(irq), 1);
    step(1'b0, 1'b0, 9'h000, 5'b0);
    chk("R4 irq dropped", 32'(irq), 0);

    // R7 interrupts run with enable low in video mode
    step(1'b1, 1'b0, 9'h010, 5'b0);
    step(1'b0, 1'b0, 9'h000, 5'b0);
    chk("R7 rd stopped", 32'(mem_rd_en), 0);
    step(1'b0, 1'b0, 9'h000, 5'b00001);
    step(1'b0, 1'b0, 9'h000, 5'b0);
    chk("R7 irq while disabled", 32'(irq), 1);

    // R3 pointer load pulse
    step(1'b1, 1'b1, 9'h01F, 5'b0);
    step(1'b0, 1'b0, 9'h000, 5'b01000);
    chk("R3 load on time", 32'(ptr_load), 1);
    step(1'b0, 1'b0, 9'h000, 5'b0);
    chk("R3 load one cycle", 32'(ptr_load), 0);
    step(1'b0, 1'b0, 9'h000, 5'b10000);
    step(1'b0, 1'b0, 9'h000, 5'b01000);
    chk("R3 no load on miss", 32'(ptr_load), 0);
    chk("R3 underrun", 32'(flags[3]), 1);

    // R8 soft reset blocks pointer load
    step(1'b1, 1'b0, 9'h002, 5'b0);
    step(1'b0, 1'b0, 9'h000, 5'b0);
    step(1'b0, 1'b0, 9'h000, 5'b01000);
    chk("R8 no load in reset", 32'(ptr_load), 0);
    chk("R8 flags held", 32'(flags), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule